// File: doc/BRIEF.md
# Double-to-Integer Conversion Unit

This unit turns one IEEE 754 binary64 value into a signed integer. A select input picks the destination width: 32 or 64 bits. When the value is not a whole number, a 2-bit rounding-direction input decides the result. The unit raises an invalid flag and an inexact flag. A mask input decides what happens when the result cannot be represented: if masked, the unit returns the integer-indefinite pattern; if unmasked, it suppresses the result strobe.

The operand input is a full vector-register lane, and only its low 64 bits are read. The unit accepts a request in every cycle (`ready_o` is tied high). It registers the result and the flags, so they appear one cycle after the request. Instruction decode, register access and trap delivery sit outside the unit.

Top module: `dbl2int_cvt`

## Requirements
- R1: A request sampled with `valid_i` high makes `flag_vld_o` high in the next cycle, with `invalid_o` and `inexact_o` for that request. In a cycle with no request, `flag_vld_o`, `invalid_o`, `inexact_o` and `res_vld_o` are all 0. `ready_o` is always 1.
- R2: Only `src_i[63:0]` is converted. The value of `src_i[VEC_W-1:64]` has no effect on any output.
- R3: With `wide_i`=0 the result is a signed 32-bit integer, sign-extended onto the 64-bit `res_o`. With `wide_i`=1 the result is a signed 64-bit integer.
- R4: `rmode_i` sets the rounding direction for a value that is not a whole number: 00 rounds to nearest with ties to even, 01 rounds toward negative infinity, 10 rounds toward positive infinity, 11 rounds toward zero.
- R5: `invalid_o` is set in three cases: the operand is a NaN, the operand is an infinity, or the rounded value falls outside the signed range of the selected width.
- R6: On an invalid conversion with `inv_mask_i`=1, `res_vld_o`=1. `res_o` then holds 0xFFFFFFFF80000000 in 32-bit mode and 0x8000000000000000 in 64-bit mode.
- R7: On an invalid conversion with `inv_mask_i`=0, `res_vld_o`=0 and `invalid_o`=1.
- R8: `inexact_o` is 1 exactly when nonzero fraction bits are discarded and the conversion is not invalid.
- R9: Zero and denormal operands convert to 0, +1 or -1 according to the rounding direction and the operand sign. A nonzero operand sets `inexact_o`.
- R10: The most negative integer of each width, -2^31 or -2^63, converts without an invalid flag. +2^31 is invalid in 32-bit mode, and +2^63 is invalid in 64-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Conversion request |
| ready_o | output | 1 | Always 1 |
| src_i | input | VEC_W | Vector lane; the low 64 bits hold the binary64 operand |
| wide_i | input | 1 | 1 selects a 64-bit result, 0 selects a 32-bit result |
| rmode_i | input | 2 | Rounding direction |
| inv_mask_i | input | 1 | Mask for the invalid exception |
| res_vld_o | output | 1 | Result strobe |
| res_o | output | 64 | Converted integer |
| flag_vld_o | output | 1 | Flag strobe |
| invalid_o | output | 1 | Invalid flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The bench builds the unit with VEC_W=128 and fills the upper lane half with a changing pattern, so any leak from the ignored bits shows up in the results.

It sweeps whole-number magnitudes close to 2^31 and 2^32, and also small and 41-bit ones. Each is tried with every quarter fraction, both signs, all four rounding directions, both widths and both mask settings. This covers ties to even, carries that cross the range limit, and the masked and unmasked invalid paths.

Directed operands cover the remaining corners: NaNs, infinities, denormals, signed zero, magnitudes above 2^64, and the exact ±2^63 boundaries.

// File: rtl/dbl_cvt_pkg.sv
package dbl_cvt_pkg;
  localparam int unsigned DBL_W  = 64;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned MAN_W  = 52;
  localparam int unsigned SIG_W  = MAN_W + 1;
  localparam int unsigned BIAS_Z = 1075;  // exponent where the significand LSB weighs 1
  localparam int unsigned EXP_HUGE = 1087;  // |x| >= 2^64
  localparam int unsigned INT_W  = 64;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             sign;
    logic             special;  // NaN or infinity
    logic             huge;
    logic [INT_W-1:0] ipart;
    logic             rbit;
    logic             sticky;
  } aligned_t;
endpackage

// File: rtl/dbl_cvt_align.sv
module dbl_cvt_align
  import dbl_cvt_pkg::*;
(
  input  logic [DBL_W-1:0] dbl_i,
  output aligned_t         aln_o
);
  localparam int unsigned EXT_W = SIG_W + INT_W;

  logic [EXP_W-1:0] exp_raw, exp_eff;
  logic [SIG_W-1:0] sig;
  logic [EXP_W-1:0] rsh;
  logic [EXT_W-1:0] ext;

  assign exp_raw = dbl_i[DBL_W-2 -: EXP_W];
  assign exp_eff = (exp_raw == '0) ? EXP_W'(1) : exp_raw;  // denormals share emin
  assign sig     = {exp_raw != '0, dbl_i[MAN_W-1:0]};
  assign rsh     = EXP_W'(BIAS_Z) - exp_eff;
  assign ext     = {sig, {INT_W{1'b0}}} >> rsh[6:0];

  always_comb begin
    aln_o         = '0;
    aln_o.sign    = dbl_i[DBL_W-1];
    aln_o.special = &exp_raw;
    aln_o.huge    = exp_raw >= EXP_W'(EXP_HUGE);
    if (exp_eff >= EXP_W'(BIAS_Z)) begin
      aln_o.ipart = INT_W'(sig) << (exp_eff - EXP_W'(BIAS_Z));
    end else if (rsh > EXP_W'(INT_W)) begin
      aln_o.sticky = |sig;
    end else begin
      aln_o.ipart  = INT_W'(ext[EXT_W-1 -: SIG_W]);
      aln_o.rbit   = ext[INT_W-1];
      aln_o.sticky = |ext[INT_W-2:0];
    end
  end
endmodule

// File: rtl/dbl_cvt_round.sv
module dbl_cvt_round
  import dbl_cvt_pkg::*;
(
  input  aligned_t         aln_i,
  input  logic [1:0]       rmode_i,
  input  logic             wide_i,
  output logic [INT_W-1:0] res_o,
  output logic             inv_o,
  output logic             inx_o
);
  logic           frac_nz, inc, over;
  logic [INT_W:0] mag, lim;

  assign frac_nz = aln_i.rbit | aln_i.sticky;

  always_comb begin
    unique case (rmode_e'(rmode_i))
      RM_NEAR: inc = aln_i.rbit & (aln_i.sticky | aln_i.ipart[0]);
      RM_DOWN: inc = frac_nz & aln_i.sign;
      RM_UP:   inc = frac_nz & ~aln_i.sign;
      default: inc = 1'b0;
    endcase
  end

  assign mag   = {1'b0, aln_i.ipart} + (INT_W+1)'(inc);
  assign lim   = wide_i ? ((INT_W+1)'(1) << (INT_W-1)) : ((INT_W+1)'(1) << 31);
  assign over  = aln_i.sign ? (mag > lim) : (mag >= lim);
  assign inv_o = aln_i.special | aln_i.huge | over;
  assign inx_o = frac_nz & ~inv_o;
  assign res_o = aln_i.sign ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];

  always_comb begin
    if (!inv_o && !wide_i) begin
      p_fits32_r3: assert (res_o[INT_W-1:31] == '0 || res_o[INT_W-1:31] == '1);
    end
  end
endmodule

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt
  import dbl_cvt_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [VEC_W-1:0] src_i,
  input  logic             wide_i,
  input  logic [1:0]       rmode_i,
  input  logic             inv_mask_i,
  output logic             res_vld_o,
  output logic [INT_W-1:0] res_o,
  output logic             flag_vld_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [INT_W-1:0] INDEF64 = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] INDEF32 = {{(INT_W-31){1'b1}}, 31'b0};

  aligned_t         aln;
  logic [INT_W-1:0] cvt_res;
  logic             cvt_inv, cvt_inx, wide_q;

  assign ready_o = 1'b1;

  dbl_cvt_align u_align (
    .dbl_i (src_i[DBL_W-1:0]),
    .aln_o (aln)
  );

  dbl_cvt_round u_round (
    .aln_i   (aln),
    .rmode_i (rmode_i),
    .wide_i  (wide_i),
    .res_o   (cvt_res),
    .inv_o   (cvt_inv),
    .inx_o   (cvt_inx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o  <= 1'b0;
      res_o      <= '0;
      flag_vld_o <= 1'b0;
      invalid_o  <= 1'b0;
      inexact_o  <= 1'b0;
      wide_q     <= 1'b0;
    end else begin
      flag_vld_o <= valid_i;
      invalid_o  <= valid_i & cvt_inv;
      inexact_o  <= valid_i & cvt_inx;
      res_vld_o  <= valid_i & (~cvt_inv | inv_mask_i);
      wide_q     <= wide_i;
      if (!valid_i || (cvt_inv && !inv_mask_i)) res_o <= '0;
      else if (cvt_inv)                         res_o <= wide_i ? INDEF64 : INDEF32;
      else                                      res_o <= cvt_res;
    end
  end

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flag_vld_o);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_vld_o |-> !invalid_o && !inexact_o && !res_vld_o);
  p_indef_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o && invalid_o |-> res_o == (wide_q ? INDEF64 : INDEF32));
  p_sext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o && !wide_q |-> res_o[INT_W-1:32] == {32{res_o[31]}});
  p_flag_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_vld_o |-> !(invalid_o && inexact_o));
  p_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni) ready_o);
endmodule

// File: tb/dbl2int_cvt_tb_top.sv
`timescale 1ns/1ps
module dbl2int_cvt_tb_top;
  localparam int unsigned VEC_W = 128;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid = 1'b0;
  logic             ready;
  logic [VEC_W-1:0] src = '0;
  logic             wide = 1'b0;
  logic [1:0]       rmode = 2'b00;
  logic             mask = 1'b1;
  logic             res_vld, flag_vld, inv, inx;
  logic [63:0]      res;

  int unsigned n_chk = 0, n_fail = 0;
  logic [63:0] upper_pat = 64'hA5A5_0F0F_3C3C_9696;

  always #2.5 clk = ~clk;

  dbl2int_cvt #(.VEC_W(VEC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .src_i(src), .wide_i(wide), .rmode_i(rmode), .inv_mask_i(mask),
    .res_vld_o(res_vld), .res_o(res), .flag_vld_o(flag_vld),
    .invalid_o(inv), .inexact_o(inx)
  );

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] dbl,
                       input logic e_vld, input logic [63:0] e_res,
                       input logic e_inv, input logic e_inx);
    n_chk++;
    if (!flag_vld || res_vld !== e_vld || inv !== e_inv || inx !== e_inx ||
        (e_vld && res !== e_res)) begin
      n_fail++;
      $display("FAIL %s src=%h w=%0d rm=%0d m=%0d: actual vld=%0b res=%h inv=%0b inx=%0b fv=%0b, expected vld=%0b res=%h inv=%0b inx=%0b",
               tag, dbl, wide, rmode, mask, res_vld, res, inv, inx, flag_vld,
               e_vld, e_res, e_inv, e_inx);
    end
  endtask

  task automatic apply(input logic [63:0] dbl, input logic w, input logic [1:0] rm,
                       input logic m);
    @(negedge clk);
    upper_pat = {upper_pat[62:0], upper_pat[63] ^ upper_pat[61]};
    src   = {upper_pat, dbl};
    wide  = w;
    rmode = rm;
    mask  = m;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  // reference for value (-1)^s * (k + q/4)
  task automatic model(input logic s, input longint unsigned k, input int q,
                       input logic [1:0] rm, input logic w, input logic m,
                       output logic e_vld, output logic [63:0] e_res,
                       output logic e_inv, output logic e_inx);
    logic            up;
    logic [64:0]     mag, lim;
    up = 1'b0;
    case (rm)
      2'b00: up = (q > 2) || (q == 2 && k[0]);
      2'b01: up = s && q != 0;
      2'b10: up = !s && q != 0;
      default: up = 1'b0;
    endcase
    mag   = {1'b0, k} + 65'(up);
    lim   = w ? (65'd1 << 63) : (65'd1 << 31);
    e_inv = s ? (mag > lim) : (mag >= lim);
    e_inx = (q != 0) && !e_inv;
    e_vld = !e_inv || m;
    if (e_inv) e_res = w ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
    else       e_res = s ? (64'd0 - mag[63:0]) : mag[63:0];
  endtask

  function automatic logic [63:0] mk_dbl(input logic s, input longint unsigned k, input int q);
    real r;
    r = real'(k) + real'(q) * 0.25;
    if (s) r = -r;
    return $realtobits(r);
  endfunction

  task automatic directed(input string tag, input logic [63:0] dbl, input logic w,
                          input logic [1:0] rm, input logic m, input logic e_vld,
                          input logic [63:0] e_res, input logic e_inv, input logic e_inx);
    apply(dbl, w, rm, m);
    check(tag, dbl, e_vld, e_res, e_inv, e_inx);
  endtask

  longint unsigned kset [13] = '{0, 1, 2, 3, 6, 7, 64'd2147483646, 64'd2147483647,
                                  64'd2147483648, 64'd2147483649, 64'd4294967295,
                                  64'd1 << 40, (64'd1 << 40) + 1};

  initial begin
    logic            e_vld, e_inv, e_inx;
    logic [63:0]     e_res, d;
    #12;
    n_chk++;  // reset state, R1
    if (res_vld !== 1'b0 || flag_vld !== 1'b0 || inv !== 1'b0 || inx !== 1'b0 || res !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: actual vld=%0b fv=%0b res=%h, expected 0 0 0", res_vld, flag_vld, res);
    end
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7 R8 R10 sweep
    foreach (kset[ki]) begin
      for (int q = 0; q < 4; q++) begin
        for (int s = 0; s < 2; s++) begin
          for (int rm = 0; rm < 4; rm++) begin
            for (int w = 0; w < 2; w++) begin
              for (int m = 0; m < 2; m++) begin
                d = mk_dbl(s[0], kset[ki], q);
                model(s[0], kset[ki], q, rm[1:0], w[0], m[0], e_vld, e_res, e_inv, e_inx);
                apply(d, w[0], rm[1:0], m[0]);
                check("R4/R5/R6/R7/R8 sweep", d, e_vld, e_res, e_inv, e_inx);
              end
            end
          end
        end
      end
    end

    // R1: no request -> quiet flags
    @(negedge clk);
    n_chk++;
    if (flag_vld !== 1'b0 || res_vld !== 1'b0 || inv !== 1'b0 || inx !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: actual fv=%0b vld=%0b inv=%0b inx=%0b, expected all 0", flag_vld, res_vld, inv, inx);
    end

    // R5 specials
    directed("R5 qNaN masked",   64'h7FF8_0000_0000_0000, 1'b0, 2'b00, 1'b1, 1'b1, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
    directed("R5 NaN w64",       64'hFFF0_0000_0000_0001, 1'b1, 2'b11, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0);
    directed("R5 +inf",          64'h7FF0_0000_0000_0000, 1'b1, 2'b00, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0);
    directed("R7 -inf unmasked", 64'hFFF0_0000_0000_0000, 1'b1, 2'b00, 1'b0, 1'b0, 64'h0, 1'b1, 1'b0);
    directed("R5 2^70 w64",      64'h4450_0000_0000_0000, 1'b1, 2'b00, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0);
    // R10 boundaries
    directed("R10 -2^63 w64",    64'hC3E0_0000_0000_0000, 1'b1, 2'b00, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0);
    directed("R10 +2^63 w64",    64'h43E0_0000_0000_0000, 1'b1, 2'b00, 1'b0, 1'b0, 64'h0, 1'b1, 1'b0);
    directed("R10 max<2^63",     64'h43DF_FFFF_FFFF_FFFF, 1'b1, 2'b01, 1'b1, 1'b1, 64'h7FFF_FFFF_FFFF_FC00, 1'b0, 1'b0);
    directed("R10 -2^31 w32",    64'hC1E0_0000_0000_0000, 1'b0, 2'b00, 1'b1, 1'b1, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0);
    directed("R3 2^40 w32",      64'h4270_0000_0000_0000, 1'b0, 2'b00, 1'b1, 1'b1, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
    // R9 zeros and denormals
    directed("R9 +0",            64'h0000_0000_0000_0000, 1'b0, 2'b10, 1'b1, 1'b1, 64'h0, 1'b0, 1'b0);
    directed("R9 -0 down",       64'h8000_0000_0000_0000, 1'b1, 2'b01, 1'b1, 1'b1, 64'h0, 1'b0, 1'b0);
    directed("R9 denorm near",   64'h0000_0000_0000_0001, 1'b0, 2'b00, 1'b1, 1'b1, 64'h0, 1'b0, 1'b1);
    directed("R9 denorm up",     64'h0000_0000_0000_0001, 1'b0, 2'b10, 1'b1, 1'b1, 64'h1, 1'b0, 1'b1);
    directed("R9 -denorm down",  64'h800F_FFFF_FFFF_FFFF, 1'b1, 2'b01, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    directed("R9 -denorm up",    64'h800F_FFFF_FFFF_FFFF, 1'b0, 2'b10, 1'b1, 1'b1, 64'h0, 1'b0, 1'b1);
    directed("R9 -denorm zero",  64'h8000_0000_0000_0001, 1'b0, 2'b11, 1'b1, 1'b1, 64'h0, 1'b0, 1'b1);
    // R8 tiny normal, R4 tie to even
    directed("R8 1e-300 up",     64'h01A5_6E1F_C2F8_F359, 1'b1, 2'b10, 1'b1, 1'b1, 64'h1, 1'b0, 1'b1);
    directed("R4 2.5 near",      64'h4004_0000_0000_0000, 1'b0, 2'b00, 1'b1, 1'b1, 64'h2, 1'b0, 1'b1);
    directed("R4 -2.5 near",     64'hC004_0000_0000_0000, 1'b1, 2'b00, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1);

    // R2: upper lane bits all ones vs all zeros
    @(negedge clk);
    src = {64'hFFFF_FFFF_FFFF_FFFF, 64'h4014_0000_0000_0000}; wide = 1'b0; rmode = 2'b00; mask = 1'b0; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
    check("R2 upper ones", 64'h4014_0000_0000_0000, 1'b1, 64'h5, 1'b0, 1'b0);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule